// File: doc/BRIEF.md
# ATA Task File Address Remapper

This block sits between the host side of a removable-card bus and the register interface of an ATA task file. Each host access carries an offset. The block folds that offset into a small register space according to the addressing mode that the card configuration logic has selected. It answers some registers itself and forwards the rest to the task file. The disk model and the configuration register file are outside the block. The task file connects through a one-cycle request port with combinational read data. The configuration side supplies the mode, the power-down state and the drive state through plain inputs.

The block answers four registers itself: alternate status, device control, device address and the odd-byte holding register. It steers both data-port aliases and the error/features register to fixed task-file indices. A device-control write with the soft-reset bit set raises a one-cycle card reset pulse. That pulse clears the control register and the byte-cycle flag. A forwarded write to an ordinary task-file register while the card is powered down raises a wake strobe in the same cycle.

Top module: `ata_tf_remap`

## Requirements
- R1: Mode code 0 (memory window): offsets whose value shifted right by 10 equals 1 (0x400 to 0x7FF) fold to offset 0. Every other offset is used unchanged.
- R2: Mode code 1 (contiguous IO): only bits 3:0 of the offset are kept.
- R3: Mode code 2 (primary IO): offsets 0x1F0 to 0x1FF become offset minus 0x1F0. Offsets 0x3F0 to 0x3FF become offset minus 0x3E8. Other offsets are unchanged.
- R4: Mode code 3 (secondary IO): offsets 0x170 to 0x17F become offset minus 0x170. Offsets 0x370 to 0x37F become offset minus 0x368. Other offsets are unchanged.
- R5: Any mode code other than 0 to 3 leaves the offset unchanged.
- R6: Folded offsets 0x0 and 0x8 are forwarded as a 16-bit data access (tf_wide_o=1) to index 0. Any folded offset that is not 0x0, 0x8, 0x9, 0xD, 0xE or 0xF is forwarded with index equal to its bits 2:0 and tf_wide_o=0. Write data passes through unchanged.
- R7: Folded offset 0xD is forwarded to index 1 for both reads and writes.
- R8: A read of folded offset 0xE returns drv_status_i, zero-extended, when drv_present_i is 1, and 0 otherwise. It is not forwarded.
- R9: A write to folded offset 0xE loads bits 7:0 into devctl_o. If bit 2 of the written value is set, then devctl_o and byte_phase_o become 0 instead, and card_reset_o is 1 for the single cycle after the write.
- R10: A read of folded offset 0xF returns 0xC2 with bits 5:2 replaced by the inverted drv_select_i. It is not forwarded.
- R11: A write to folded offset 0x9 stores bits 7:0 in the low byte of a holding register, clears its high byte and toggles byte_phase_o. A read of 0x9 returns the holding register's high byte, which is therefore 0. Neither access is forwarded.
- R12: wake_o is 1 in the cycle of a forwarded non-data write other than index-1 features, and only while pwrdn_i is 1.
- R13: rsp_valid_o is 1 exactly in the cycle after each read request, with the read value on rsp_rdata_o. Task-file read data is sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 6 | Addressing mode code from configuration logic |
| req_valid_i | input | 1 | Host access in this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | ADDR_W | Host offset |
| req_wdata_i | input | DATA_W | Host write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | DATA_W | Read data |
| tf_valid_o | output | 1 | Forwarded task-file access |
| tf_write_o | output | 1 | Forwarded access is a write |
| tf_idx_o | output | 3 | Task-file register index |
| tf_wide_o | output | 1 | Forwarded access is the 16-bit data port |
| tf_wdata_o | output | DATA_W | Forwarded write data |
| tf_rdata_i | input | DATA_W | Task-file read data, same cycle |
| drv_present_i | input | 1 | A drive is attached |
| drv_status_i | input | 8 | Drive status byte |
| drv_select_i | input | 4 | Drive-select value |
| pwrdn_i | input | 1 | Card is in power-down |
| wake_o | output | 1 | Wake request to configuration logic |
| devctl_o | output | 8 | Device control register |
| card_reset_o | output | 1 | Card reset pulse |
| byte_phase_o | output | 1 | Byte-cycle flag |

## Verification
The read response register still holds the previous read when the next request is already being decoded. A back-to-back read followed by a write can therefore finish one read and start a forwarded, waking write in the same cycle. The bench provokes this by issuing requests on consecutive edges with no idle cycle. The scoreboard judges the delayed read data. In the same cycle, the forwarded index and the wake strobe of the following write are checked, so neither may disturb the other.

// File: rtl/ata_tf_remap_pkg.sv
package ata_tf_remap_pkg;
  localparam int MODE_W = 6;
  localparam logic [MODE_W-1:0] MODE_MEM = 6'd0;
  localparam logic [MODE_W-1:0] MODE_CONTIG = 6'd1;
  localparam logic [MODE_W-1:0] MODE_PRI = 6'd2;
  localparam logic [MODE_W-1:0] MODE_SEC = 6'd3;

  localparam int OFF_DATA0 = 'h0;
  localparam int OFF_DATA1 = 'h8;
  localparam int OFF_HOLD = 'h9;
  localparam int OFF_ERRFEAT = 'hD;
  localparam int OFF_CTLSTAT = 'hE;
  localparam int OFF_DEVADDR = 'hF;
endpackage

// File: rtl/ata_addr_fold.sv
module ata_addr_fold
  import ata_tf_remap_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] off_o
);
  localparam int WIN_SH = 4;
  localparam int PAGE_SH = 10;

  logic [ADDR_W-1:0] win;
  logic [ADDR_W-1:0] page;
  assign win = addr_i >> WIN_SH;
  assign page = addr_i >> PAGE_SH;

  always_comb begin
    off_o = addr_i;
    unique case (mode_i)
      MODE_MEM: if (page == ADDR_W'(1)) off_o = '0;
      MODE_CONTIG: off_o = addr_i & ADDR_W'('hF);
      MODE_PRI: begin
        if (win == ADDR_W'('h3F)) off_o = addr_i - ADDR_W'('h3E8);
        else if (win == ADDR_W'('h1F)) off_o = addr_i - ADDR_W'('h1F0);
      end
      MODE_SEC: begin
        if (win == ADDR_W'('h37)) off_o = addr_i - ADDR_W'('h368);
        else if (win == ADDR_W'('h17)) off_o = addr_i - ADDR_W'('h170);
      end
      default: off_o = addr_i;
    endcase
  end
endmodule

// File: rtl/ata_local_regs.sv
module ata_local_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              hold_we_i,
  input  logic [7:0]        wbyte_i,
  output logic [7:0]        devctl_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              phase_o,
  output logic              reset_pulse_o
);
  localparam int SRST_BIT = 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      devctl_o      <= '0;
      hold_o        <= '0;
      phase_o       <= 1'b0;
      reset_pulse_o <= 1'b0;
    end else begin
      reset_pulse_o <= 1'b0;
      if (ctl_we_i) begin
        if (wbyte_i[SRST_BIT]) begin
          devctl_o      <= '0;
          phase_o       <= 1'b0;
          reset_pulse_o <= 1'b1;
        end else begin
          devctl_o <= wbyte_i;
        end
      end else if (hold_we_i) begin
        hold_o  <= DATA_W'(wbyte_i);
        phase_o <= ~phase_o;
      end
    end
  end
endmodule

// File: rtl/ata_tf_remap.sv
module ata_tf_remap
  import ata_tf_remap_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        mode_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              tf_valid_o,
  output logic              tf_write_o,
  output logic [2:0]        tf_idx_o,
  output logic              tf_wide_o,
  output logic [DATA_W-1:0] tf_wdata_o,
  input  logic [DATA_W-1:0] tf_rdata_i,
  input  logic              drv_present_i,
  input  logic [7:0]        drv_status_i,
  input  logic [3:0]        drv_select_i,
  input  logic              pwrdn_i,
  output logic              wake_o,
  output logic [7:0]        devctl_o,
  output logic              card_reset_o,
  output logic              byte_phase_o
);
  localparam int HB = DATA_W / 2;

  logic [ADDR_W-1:0] off;
  logic is_data, is_hold, is_feat, is_ctl, is_dev, fwd;
  logic rd, wr;
  logic [DATA_W-1:0] hold_q, rd_mux, rsp_q;
  logic rsp_v_q;

  ata_addr_fold #(.ADDR_W(ADDR_W)) u_fold (
    .mode_i (mode_i),
    .addr_i (req_addr_i),
    .off_o  (off)
  );

  assign is_data = (off == ADDR_W'(OFF_DATA0)) || (off == ADDR_W'(OFF_DATA1));
  assign is_hold = off == ADDR_W'(OFF_HOLD);
  assign is_feat = off == ADDR_W'(OFF_ERRFEAT);
  assign is_ctl  = off == ADDR_W'(OFF_CTLSTAT);
  assign is_dev  = off == ADDR_W'(OFF_DEVADDR);
  assign fwd     = !(is_hold || is_ctl || is_dev);
  assign rd      = req_valid_i && !req_write_i;
  assign wr      = req_valid_i && req_write_i;

  assign tf_valid_o = req_valid_i && fwd;
  assign tf_write_o = req_write_i;
  assign tf_wide_o  = is_data;
  assign tf_wdata_o = req_wdata_i;
  always_comb begin
    if (is_data)      tf_idx_o = 3'd0;
    else if (is_feat) tf_idx_o = 3'd1;
    else              tf_idx_o = off[2:0];
  end

  // plain task-file writes revive a powered-down card
  assign wake_o = wr && fwd && !is_data && !is_feat && pwrdn_i;

  ata_local_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctl_we_i      (wr && is_ctl),
    .hold_we_i     (wr && is_hold),
    .wbyte_i       (req_wdata_i[7:0]),
    .devctl_o      (devctl_o),
    .hold_o        (hold_q),
    .phase_o       (byte_phase_o),
    .reset_pulse_o (card_reset_o)
  );

  always_comb begin
    if (is_ctl)       rd_mux = drv_present_i ? DATA_W'(drv_status_i) : '0;
    else if (is_dev)  rd_mux = DATA_W'({2'b11, ~drv_select_i, 2'b10});
    else if (is_hold) rd_mux = DATA_W'(hold_q[DATA_W-1:HB]);
    else              rd_mux = tf_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      rsp_v_q <= rd;
      if (rd) rsp_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rsp_v_q;
  assign rsp_rdata_o = rsp_q;
endmodule

// File: rtl/ata_tf_remap_chk.sv
module ata_tf_remap_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_write_i,
  input logic rsp_valid_o,
  input logic tf_valid_o,
  input logic tf_write_o,
  input logic tf_wide_o,
  input logic pwrdn_i,
  input logic wake_o,
  input logic [7:0] devctl_o,
  input logic card_reset_o,
  input logic byte_phase_o
);
  // R13
  rd_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i |=> rsp_valid_o);
  // R13
  no_spur_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);
  // R9
  rst_clears_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_reset_o |-> devctl_o == 8'h00 && !byte_phase_o);
  // R9
  rst_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_reset_o) |-> $past(req_valid_i && req_write_i));
  // R12
  wake_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> tf_valid_o && tf_write_o && pwrdn_i && !tf_wide_o);
  // R6
  fwd_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_valid_o |-> req_valid_i && (tf_write_o == req_write_i));
  // R11
  phase_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(byte_phase_o));
endmodule

bind ata_tf_remap ata_tf_remap_chk u_chk (.*);

// File: tb/ata_tf_remap_bench.sv
`timescale 1ns/1ps
module ata_tf_remap_bench;
  localparam int AW = 11;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] mode;
  logic req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic tf_valid, tf_write, tf_wide;
  logic [2:0] tf_idx;
  logic [DW-1:0] tf_wdata, tf_rdata;
  logic drv_present;
  logic [7:0] drv_status;
  logic [3:0] drv_select;
  logic pwrdn, wake, card_reset, byte_phase;
  logic [7:0] devctl;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  assign tf_rdata = {8'hB7, 5'h0, tf_idx};

  ata_tf_remap #(.ADDR_W(AW), .DATA_W(DW)) u_ata_tf_remap (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .tf_valid_o(tf_valid), .tf_write_o(tf_write), .tf_idx_o(tf_idx),
    .tf_wide_o(tf_wide), .tf_wdata_o(tf_wdata), .tf_rdata_i(tf_rdata),
    .drv_present_i(drv_present), .drv_status_i(drv_status),
    .drv_select_i(drv_select), .pwrdn_i(pwrdn), .wake_o(wake),
    .devctl_o(devctl), .card_reset_o(card_reset), .byte_phase_o(byte_phase)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] fold(logic [5:0] m, logic [AW-1:0] a);
    case (m)
      6'd0: return (a >= 11'h400 && a <= 11'h7FF) ? 11'h0 : a;
      6'd1: return {7'h0, a[3:0]};
      6'd2: if (a >= 11'h3F0 && a <= 11'h3FF) return a - 11'h3E8;
            else if (a >= 11'h1F0 && a <= 11'h1FF) return a - 11'h1F0;
            else return a;
      6'd3: if (a >= 11'h370 && a <= 11'h37F) return a - 11'h368;
            else if (a >= 11'h170 && a <= 11'h17F) return a - 11'h170;
            else return a;
      default: return a;
    endcase
  endfunction

  // drive one request at a negedge, check same-cycle task-file outputs
  task automatic access(string req, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [AW-1:0] o;
    logic local_reg, dat, feat;
    logic [2:0] idx;
    logic [DW-1:0] er;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    o = fold(mode, a);
    dat = (o == 0) || (o == 8);
    feat = (o == 'hD);
    local_reg = (o == 'h9) || (o == 'hE) || (o == 'hF);
    idx = dat ? 3'd0 : feat ? 3'd1 : o[2:0];
    check({req, " tf_valid"}, tf_valid, !local_reg);
    if (!local_reg) begin
      check({req, " tf_idx"}, tf_idx, idx);
      check({req, " tf_wide"}, tf_wide, dat);
      if (w) check({req, " tf_wdata"}, tf_wdata, d);
    end
    // R12
    check({req, " R12 wake"}, wake, w && !local_reg && !dat && !feat && pwrdn);
    if (!w) begin
      if (o == 'hE) er = drv_present ? {8'h0, drv_status} : 16'h0;
      else if (o == 'hF) er = {8'h0, 2'b11, ~drv_select, 2'b10};
      else if (o == 'h9) er = 16'h0;
      else er = {8'hB7, 5'h0, idx};
      exp_q.push_back(er);
      tag_q.push_back(req);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R13 spurious rsp", 1, 0);
      else check({tag_q.pop_front(), " R13 rsp"}, rsp_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    mode = 6'd0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    drv_present = 1; drv_status = 8'h58; drv_select = 4'h0; pwrdn = 0;
    repeat (3) @(negedge clk);
    check("R13 reset rsp_valid", rsp_valid, 0);
    check("R9 reset devctl", devctl, 0);
    check("R11 reset phase", byte_phase, 0);
    check("R9 reset card_reset", card_reset, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 memory window
    mode = 6'd0;
    access("R1 fold 405", 0, 11'h405, 0);
    access("R1 pass 003", 0, 11'h003, 0);
    access("R1 fold 40E", 0, 11'h40E, 0);
    access("R1 pass 00F R10", 0, 11'h00F, 0);
    idle();
    // R2 contiguous
    mode = 6'd1;
    access("R2 1F3", 0, 11'h1F3, 0);
    access("R2 7FE R8", 0, 11'h7FE, 0);
    idle();
    // R3 primary
    mode = 6'd2;
    access("R3 1F7", 0, 11'h1F7, 0);
    access("R3 3F6 R8", 0, 11'h3F6, 0);
    access("R3 3F7 R10", 0, 11'h3F7, 0);
    access("R3 3F0 R6", 0, 11'h3F0, 0);
    access("R3 1FD R7", 0, 11'h1FD, 0);
    access("R3 3F9 R6", 0, 11'h3F9, 0);
    idle();
    // R4 secondary
    mode = 6'd3; drv_select = 4'h1;
    access("R4 176", 0, 11'h176, 0);
    access("R4 377 R10", 0, 11'h377, 0);
    access("R4 170 R6", 0, 11'h170, 0);
    access("R4 1F6 unmapped", 0, 11'h1F6, 0);
    idle();
    // R5 unknown mode
    mode = 6'd5;
    access("R5 00E", 0, 11'h00E, 0);
    access("R5 40E", 0, 11'h40E, 0);
    drv_present = 0;
    access("R8 absent", 0, 11'h00E, 0);
    drv_present = 1;
    idle();

    // R11 holding register and byte phase
    mode = 6'd1;
    access("R11 wr9", 1, 11'h009, 16'h12AB);
    check("R11 phase set", byte_phase, 1);
    access("R11 rd9", 0, 11'h009, 0);
    check("R11 phase held on read", byte_phase, 1);
    access("R11 wr9 again", 1, 11'h009, 16'h00CD);
    check("R11 phase toggled", byte_phase, 0);
    idle();

    // R9 device control
    access("R9 ctl 02", 1, 11'h00E, 16'h0002);
    check("R9 devctl loaded", devctl, 8'h02);
    check("R9 no reset", card_reset, 0);
    access("R11 wr9 pre-reset", 1, 11'h009, 16'h0011);
    check("R11 phase before reset", byte_phase, 1);
    access("R9 ctl 06", 1, 11'h00E, 16'h0006);
    check("R9 reset pulse", card_reset, 1);
    check("R9 devctl cleared", devctl, 0);
    check("R9 phase cleared", byte_phase, 0);
    idle();
    check("R9 pulse one cycle", card_reset, 0);

    // R12 wake conditions
    pwrdn = 1;
    access("R12 wr idx3 pwrdn", 1, 11'h003, 16'h0055);
    access("R7 wr feat pwrdn", 1, 11'h00D, 16'h0003);
    access("R6 wr data pwrdn", 1, 11'h008, 16'hBEEF);
    pwrdn = 0;
    access("R12 wr idx3 awake", 1, 11'h003, 16'h0055);
    idle();

    // back-to-back read then waking write
    pwrdn = 1; mode = 6'd2;
    access("R13 b2b rd 1F2", 0, 11'h1F2, 0);
    access("R12 b2b wr 1F4", 1, 11'h1F4, 16'h00A1);
    access("R13 b2b rd 3F6", 0, 11'h3F6, 0);
    access("R12 b2b wr 1F5", 1, 11'h1F5, 16'h00A2);
    pwrdn = 0;
    idle();
    idle();
    check("R13 queue drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule